// File: doc/BRIEF.md
# SIMD Half-Operand Modifier Unit

This block sits on the operand fetch path of a SIMD datapath. It rewrites a 128-bit source operand so that every field of a selected power-of-two width holds only one half of its original contents. Under the high-half modifier, the upper half of each field moves down into the lower half. Under the low-half modifier, the lower half stays where it is. In both cases the vacated upper half of the field is cleared. With no modifier the operand passes through untouched. Field widths of 1, 2, 4, 8, 16, 32, 64 and 128 bits are all supported, including the narrow 2-bit and 4-bit fields used for packed nucleotide codes and packed decimal digits.

Bit positions are numbered from the most significant end: position 0 is the leftmost bit of the operand. One decoded width vector is shared by both paths. Each of the two source operands has its own pair of modifier flags. The half selection is pure AND-OR logic per output bit. The result of each path is registered once, so the modified operands are available one clock after the inputs are presented.

Top module: `halfop_modifier`

## Requirements
- R1: A synchronous active-high `rst` clears both `op0_out` and `op1_out` to all zeros on the next rising clock edge.
- R2: When both modifier flags of an operand are 0, that operand's output equals its input, whatever the width vector holds.
- R3: Operand port bit [p] is position p, and position 0 is the most significant bit. `width_sel` bit k selects fields of 2^k bits aligned at multiples of 2^k, and at most one bit is set. For example, with the 2-bit width and the high flag, position 41 receives input position 40; with the 16-bit width it receives position 33; with the 64-bit width it receives position 9.
- R4: The high flag and the low flag of one operand are never both 1. With the high flag and a width n ≥ 2, each field becomes its original value shifted right by n/2 as an unsigned number: the old high half lands in the low half and the high half is zero.
- R5: With the low flag and a width n ≥ 2, each field keeps its low n/2 bits in place and its high n/2 bits become zero.
- R6: With the 1-bit width (`width_sel` = 8'b0000_0001), the high flag yields an all-zero output and the low flag passes the input unchanged.
- R7: The two operand paths act independently: each uses its own input and its own flags together with the shared width vector.
- R8: A modifier flag combined with an all-zero `width_sel` yields an all-zero output.
- R9: Outputs are registered. A new input is reflected at the outputs after exactly one rising edge, and the outputs hold their value between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 8 | One-hot field width, bit k selects 2^k bits |
| op0_in | input | 128 | First source operand, bit [0] most significant |
| op0_hi | input | 1 | First operand: select high halves |
| op0_lo | input | 1 | First operand: select low halves |
| op1_in | input | 128 | Second source operand, bit [0] most significant |
| op1_hi | input | 1 | Second operand: select high halves |
| op1_lo | input | 1 | Second operand: select low halves |
| op0_out | output | 128 | Modified first operand, registered |
| op1_out | output | 128 | Modified second operand, registered |

## Verification
The assertions check several properties on every cycle:
- Pass-through when no flag is set.
- Zeros in the upper half of each field under either flag.
- Low halves preserved under the low flag.
- All-zero output for the 1-bit width with the high flag.
- Flag exclusivity and the at-most-one-hot width vector.
- The cleared state after reset.

None of the assertions says where the moved bits land under the high flag. Only the bench's arithmetic reference shows that, by comparing against field >> n/2 over random operands at every width. The bench's scenarios also cover the position-41 examples, two operands running different modifiers in the same cycle, the zero width vector, and outputs holding steady in the middle of a cycle.

// File: rtl/halfop_pkg.sv
package halfop_pkg;
  localparam int HOM_W  = 128;  // operand width in bits
  localparam int HOM_LW = 7;    // log2 of the operand width

  // distance a bit travels under the high-half flag for width index k
  function automatic int half_span(input int k);
    return (k == 0) ? 0 : (1 << (k - 1));
  endfunction
endpackage

// File: rtl/halfop_lane.sv
module halfop_lane
  import halfop_pkg::*;
#(
  parameter int W  = HOM_W,
  parameter int LW = HOM_LW
) (
  input  logic [0:W-1] r,
  input  logic [LW:0]  wsel,
  input  logic         hi,
  input  logic         lo,
  output logic [0:W-1] s
);
  logic pass_all;
  assign pass_all = ~(hi | lo);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [LW:0] take_hi;   // per width: value moved in from the high half
    logic [LW:0] keep_lo;   // per width: this bit sits in a low half

    for (genvar k = 0; k <= LW; k++) begin : g_w
      if (k == 0) begin : g_w1
        assign take_hi[k] = 1'b0;
        assign keep_lo[k] = wsel[k];
      end else if (((i >> (k - 1)) & 1) == 1) begin : g_low
        localparam int SPAN = half_span(k);
        assign take_hi[k] = wsel[k] & r[i - SPAN];
        assign keep_lo[k] = wsel[k];
      end else begin : g_high
        assign take_hi[k] = 1'b0;
        assign keep_lo[k] = 1'b0;
      end
    end

    assign s[i] = (hi & (|take_hi)) | ((pass_all | (lo & (|keep_lo))) & r[i]);
  end
endmodule

// File: rtl/halfop_outreg.sv
module halfop_outreg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [0:W-1] d,
  output logic [0:W-1] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/halfop_modifier.sv
module halfop_modifier
  import halfop_pkg::*;
#(
  parameter int W  = HOM_W,
  parameter int LW = HOM_LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW:0]   width_sel,
  input  logic [0:W-1]  op0_in,
  input  logic          op0_hi,
  input  logic          op0_lo,
  input  logic [0:W-1]  op1_in,
  input  logic          op1_hi,
  input  logic          op1_lo,
  output logic [0:W-1]  op0_out,
  output logic [0:W-1]  op1_out
);
  localparam int NOPS = 2;

  logic [0:W-1] src  [NOPS];
  logic [0:W-1] comb [NOPS];
  logic [0:W-1] dst  [NOPS];
  logic         f_hi [NOPS];
  logic         f_lo [NOPS];

  assign src[0]  = op0_in;
  assign src[1]  = op1_in;
  assign f_hi[0] = op0_hi;
  assign f_hi[1] = op1_hi;
  assign f_lo[0] = op0_lo;
  assign f_lo[1] = op1_lo;
  assign op0_out = dst[0];
  assign op1_out = dst[1];

  // upper-half positions for the selected width, used only by the checks
  logic [0:W-1] upper_mask;
  always_comb begin
    for (int p = 0; p < W; p++) begin
      upper_mask[p] = 1'b0;
      for (int k = 1; k <= LW; k++)
        if (width_sel[k] && (((p >> (k - 1)) & 1) == 0)) upper_mask[p] = 1'b1;
    end
  end

  AST_WIDTH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(width_sel)); // R3

  for (genvar o = 0; o < NOPS; o++) begin : g_op
    halfop_lane #(.W(W), .LW(LW)) u_lane (
      .r    (src[o]),
      .wsel (width_sel),
      .hi   (f_hi[o]),
      .lo   (f_lo[o]),
      .s    (comb[o])
    );

    halfop_outreg #(.W(W)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (comb[o]),
      .q   (dst[o])
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (dst[o] == '0)); // R1
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
      (!f_hi[o] && !f_lo[o]) |=> (dst[o] == $past(src[o]))); // R2
    AST_MOD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(f_hi[o] && f_lo[o])); // R4
    AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (rst)
      (f_hi[o] || f_lo[o]) |=> ((dst[o] & $past(upper_mask)) == '0)); // R4
    AST_LOWER_KEPT: assert property (@(posedge clk) disable iff (rst)
      (f_lo[o] && (|width_sel)) |=>
        (((dst[o] ^ $past(src[o])) & ~$past(upper_mask)) == '0)); // R5
    AST_W1_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
      (f_hi[o] && width_sel[0]) |=> (dst[o] == '0)); // R6
  end
endmodule

// File: tb/halfop_modifier_bench.sv
`timescale 1ns/1ps
module halfop_modifier_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   width_sel = '0;
  logic [0:127] op0_in = '0, op1_in = '0;
  logic         op0_hi = 0, op0_lo = 0, op1_hi = 0, op1_lo = 0;
  logic [0:127] op0_out, op1_out;

  int checks = 0, fails = 0;
  bit done = 0;
  bit pend = 0;
  logic [0:127] exp0, exp1, last0, last1;
  string tag0, tag1;

  always #5 clk = ~clk;

  halfop_modifier u_halfop_modifier (
    .clk(clk), .rst(rst), .width_sel(width_sel),
    .op0_in(op0_in), .op0_hi(op0_hi), .op0_lo(op0_lo),
    .op1_in(op1_in), .op1_hi(op1_hi), .op1_lo(op1_lo),
    .op0_out(op0_out), .op1_out(op1_out));

  function automatic logic [127:0] fmask(input int m);
    logic [127:0] one = 128'd1;
    return (m >= 128) ? '1 : ((one << m) - one);
  endfunction

  // arithmetic reference: fields taken as unsigned numbers, MSB first
  function automatic logic [0:127] model(input logic [0:127] x, input logic [7:0] w,
                                         input bit h, input bit l);
    logic [127:0] v, res, fld;
    int k, n, sh;
    v = x;
    if (!h && !l) return x;
    if (w == 0) return '0;
    k = 0;
    for (int j = 0; j < 8; j++) if (w[j]) k = j;
    n = 1 << k;
    if (n == 1) return h ? '0 : x;
    res = '0;
    for (int f = 0; f < 128 / n; f++) begin
      sh  = 128 - (f + 1) * n;
      fld = (v >> sh) & fmask(n);
      fld = h ? (fld >> (n / 2)) : (fld & fmask(n / 2));
      res = res | (fld << sh);
    end
    return res;
  endfunction

  function automatic string tag_for(input bit h, input bit l, input logic [7:0] w);
    if (!h && !l) return "R2";
    if (w == 0)   return "R8";
    if (w[0])     return "R6";
    return h ? "R4" : "R5";
  endfunction

  task automatic check(input logic [0:127] act, input logic [0:127] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [0:127] a, input logic [0:127] b, input logic [7:0] w,
                       input bit h0, input bit l0, input bit h1, input bit l1,
                       input string forced_tag);
    @(negedge clk);
    if (pend) begin
      check(op0_out, exp0, tag0);
      check(op1_out, exp1, tag1);
      last0 = exp0;
      last1 = exp1;
    end
    op0_in = a; op1_in = b; width_sel = w;
    op0_hi = h0; op0_lo = l0; op1_hi = h1; op1_lo = l1;
    exp0 = model(a, w, h0, l0);
    exp1 = model(b, w, h1, l1);
    tag0 = (forced_tag != "") ? forced_tag : tag_for(h0, l0, w);
    tag1 = (forced_tag != "") ? forced_tag : tag_for(h1, l1, w);
    pend = 1;
  endtask

  function automatic logic [0:127] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [0:127] v;
    op0_in = '1; op1_in = '1; width_sel = 8'd2; op0_hi = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(op0_out, '0, "R1");
    check(op1_out, '0, "R1");
    rst = 0;

    // position-41 examples for widths 2, 16, 64
    v = '0; v[40] = 1'b1;
    apply(v, v, 8'b0000_0010, 1, 0, 0, 0, "R3");
    v = '0; v[33] = 1'b1;
    apply(v, v, 8'b0001_0000, 1, 0, 0, 0, "R3");
    v = '0; v[9] = 1'b1;
    apply(v, v, 8'b0100_0000, 1, 0, 0, 0, "R3");
    @(negedge clk);
    check({127'd0, op0_out[41]} , 128'd1, "R3");
    pend = 0;

    // independent paths with opposite flags, same input
    v = rnd128();
    apply(v, v, 8'b0000_1000, 1, 0, 0, 1, "R7");
    apply(v, v, 8'b0000_0100, 0, 1, 1, 0, "R7");
    apply(rnd128(), rnd128(), 8'b1000_0000, 1, 0, 0, 0, "R7");

    // 1-bit width and zero width
    apply(rnd128(), rnd128(), 8'b0000_0001, 1, 0, 0, 1, "");
    apply(rnd128(), rnd128(), 8'b0000_0000, 1, 0, 0, 1, "");
    apply(rnd128(), rnd128(), 8'b0000_0000, 0, 0, 0, 0, "");

    // outputs hold between edges
    apply('1, '1, 8'b0010_0000, 0, 0, 0, 0, "");
    apply('0, '0, 8'b0010_0000, 0, 0, 0, 0, "");
    #2;
    check(op0_out, last0, "R9");
    check(op1_out, last1, "R9");

    // random sweep over all widths and modifier combinations
    for (int t = 0; t < 600; t++) begin
      int m0, m1, k;
      logic [7:0] w;
      m0 = $urandom_range(0, 2);
      m1 = $urandom_range(0, 2);
      k  = $urandom_range(0, 8);
      w  = (k == 8) ? 8'd0 : (8'd1 << k);
      apply(rnd128(), rnd128(), w, m0 == 1, m0 == 2, m1 == 1, m1 == 2, "");
    end
    apply('0, '0, 8'd1, 0, 0, 0, 0, "");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule